// File: doc/BRIEF.md
# B-Channel Register Tap

This block gives a control processor byte-level access to one 64 kbit/s voice timeslot of a framed PCM stream. A select register names the slot. In the transmit direction, a byte written to the insert register replaces the codec's byte in the selected slot once, in the next occurrence of that slot. After that, the codec's data resumes with no further action.

In the receive direction, the byte arriving in the selected slot is captured every frame into a readable register. A "new" flag and a sticky overrun flag go with it. Writing that same register queues one byte that is pushed down the receive path instead of the line byte, at the next capture. To keep a continuous stream in either direction, the processor must write or read once per frame.

Slot timing comes from two strobes. `slot_tick` marks the first cycle of every slot. `frame_sync` comes together with the tick of slot 0. A slot sequencer has three states:
- `ST_PAST`: the selected slot is over and the block waits for a frame. This is the state after reset.
- `ST_HUNT`: the block waits for the selected slot.
- `ST_INSLOT`: the selected slot is on the line.

Its transitions are:
- ENTER, from `ST_HUNT` to `ST_INSLOT`, or from any state on a frame tick when slot 0 is selected. It loads the transmit byte.
- CLOSE, from `ST_INSLOT` to `ST_PAST` on the next tick. It captures the receive byte.
- WRAP, from `ST_INSLOT` to `ST_HUNT` when that closing tick is also a frame tick.
- REFRAME, from `ST_PAST` to `ST_HUNT` on a frame tick.

Top module: `bchan_tap`

## Requirements
- R1: After reset, every register reads as zero: SEL (address 0), TXINS (address 1), RXDATA (address 2) and STATUS (address 3). `tx_line`, `rx_path`, `tx_line_load` and `rx_path_valid` are also zero. A read returns its data in `reg_rdata` one cycle after `reg_re`.
- R2: Slots are numbered from 0 at the tick carrying `frame_sync`, and the number goes up by one at each later tick. Only the slot whose number equals SEL[2:0] is loaded on the transmit side and captured on the receive side, once per frame. This includes the last slot, whose capture happens at the next frame's tick.
- R3: After a write to TXINS, the next entry into the selected slot drives the written byte on `tx_line` in place of `tx_pcm`, once only. The entry after that carries `tx_pcm` again.
- R4: When no insert is pending, entering the selected slot drives the `tx_pcm` value present at the entry tick onto `tx_line`. `tx_line_load` pulses for one cycle, and `tx_line` is stable between loads.
- R5: STATUS bit 0 is set by a TXINS write and clears at the entry that sends the inserted byte.
- R6: At the tick that ends the selected slot, the `rx_line` byte is latched into RXDATA and STATUS bit 2 (new) is set. A read of RXDATA clears bit 2.
- R7: STATUS bit 3 (overrun) is set when a capture occurs while bit 2 is still set and RXDATA is not being read in that cycle. It stays set until STATUS is read, and that read returns it still set.
- R8: A write to RXDATA sets STATUS bit 1. The next capture then drives the written byte on `rx_path` instead of the line byte, once, and clears bit 1. RXDATA still latches the line byte.
- R9: A TXINS write made while the selected slot is in progress does not alter that slot's byte. It takes effect in the next frame.
- R10: At each capture, `rx_path` is updated and `rx_path_valid` pulses for one cycle. `rx_path` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame start, coincident with the slot-0 tick |
| slot_tick | input | 1 | First cycle of each slot |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid one cycle after `reg_re` |
| tx_pcm | input | DW | Codec transmit byte |
| tx_line | output | DW | Byte for the selected transmit slot |
| tx_line_load | output | 1 | One-cycle pulse when `tx_line` is reloaded |
| rx_line | input | DW | Receive byte of the slot just ending, valid at the next tick |
| rx_path | output | DW | Byte handed to the receive path |
| rx_path_valid | output | 1 | One-cycle pulse when `rx_path` is updated |

## Verification
The assertions assume the following about the inputs:
- `slot_tick` never arrives on two adjacent cycles, so that a load or capture pulse is always followed by a quiet cycle.
- `frame_sync` is only ever high together with `slot_tick`.
- `rx_line` still holds the ending slot's byte at the tick that closes it.

The stimulus keeps within these limits. It uses four-cycle slots, raises `frame_sync` only on a tick cycle, and changes `rx_line` only in the cycle after a tick. Register accesses are placed inside a slot, never on top of a tick, except where the timing of a write within the selected slot is itself under test.

// File: rtl/bchan_pkg.sv
package bchan_pkg;

    typedef enum logic [1:0] {
        ST_PAST   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_INSLOT = 2'd2
    } slot_st_e;

    typedef enum logic [1:0] {
        RA_SEL    = 2'd0,
        RA_TXINS  = 2'd1,
        RA_RXDATA = 2'd2,
        RA_STATUS = 2'd3
    } reg_addr_e;

    localparam int STAT_TXP = 0;
    localparam int STAT_RXI = 1;
    localparam int STAT_NEW = 2;
    localparam int STAT_OVR = 3;
    localparam int STAT_W   = 4;

endpackage

// File: rtl/bchan_slot_fsm.sv
module bchan_slot_fsm
    import bchan_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             slot_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             slot_enter,
    output logic             slot_close
);

    slot_st_e         state_q, state_d;
    logic [SEL_W-1:0] cnt_q;
    logic [SEL_W-1:0] cur;
    logic             armed;

    // slot number of the slot that starts at this tick
    assign cur   = frame_sync ? '0 : cnt_q + 1'b1;
    assign armed = (state_q == ST_HUNT) || frame_sync;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (slot_tick) cnt_q <= cur;
        end
    end

    always_comb begin
        slot_enter = slot_tick && armed && (cur == sel);
        slot_close = slot_tick && (state_q == ST_INSLOT);
        state_d    = state_q;
        unique case (state_q)
            ST_PAST: begin
                if (slot_tick && frame_sync)
                    state_d = slot_enter ? ST_INSLOT : ST_HUNT;     // REFRAME / ENTER
            end
            ST_HUNT: begin
                if (slot_enter) state_d = ST_INSLOT;               // ENTER
            end
            ST_INSLOT: begin
                if (slot_tick) begin
                    if (slot_enter)      state_d = ST_INSLOT;      // ENTER (slot 0)
                    else if (frame_sync) state_d = ST_HUNT;        // WRAP
                    else                 state_d = ST_PAST;        // CLOSE
                end
            end
            default: state_d = ST_PAST;
        endcase
    end

endmodule

// File: rtl/bchan_tx_lane.sv
module bchan_tx_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_wr,
    input  logic [DW-1:0] wdata,
    input  logic          slot_enter,
    input  logic [DW-1:0] tx_pcm,
    output logic [DW-1:0] ins_q,
    output logic          pend_q,
    output logic [DW-1:0] tx_line,
    output logic          tx_line_load
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_q        <= '0;
            pend_q       <= 1'b0;
            tx_line      <= '0;
            tx_line_load <= 1'b0;
        end else begin
            tx_line_load <= slot_enter;
            if (slot_enter) tx_line <= pend_q ? ins_q : tx_pcm;
            if (ins_wr) begin
                ins_q  <= wdata;
                pend_q <= 1'b1;      // a write during entry waits for the next frame
            end else if (slot_enter) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bchan_rx_lane.sv
module bchan_rx_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inj_wr,
    input  logic          data_rd,
    input  logic          stat_rd,
    input  logic [DW-1:0] wdata,
    input  logic          slot_close,
    input  logic [DW-1:0] rx_line,
    output logic [DW-1:0] cap_q,
    output logic          new_q,
    output logic          ovr_q,
    output logic          inj_pend_q,
    output logic [DW-1:0] rx_path,
    output logic          rx_path_valid
);

    logic [DW-1:0] inj_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q         <= '0;
            new_q         <= 1'b0;
            ovr_q         <= 1'b0;
            inj_q         <= '0;
            inj_pend_q    <= 1'b0;
            rx_path       <= '0;
            rx_path_valid <= 1'b0;
        end else begin
            rx_path_valid <= slot_close;
            if (slot_close) begin
                cap_q   <= rx_line;
                rx_path <= inj_pend_q ? inj_q : rx_line;
            end
            if (slot_close)   new_q <= 1'b1;
            else if (data_rd) new_q <= 1'b0;
            if (slot_close && new_q && !data_rd) ovr_q <= 1'b1;
            else if (stat_rd)                    ovr_q <= 1'b0;
            if (inj_wr) begin
                inj_q      <= wdata;
                inj_pend_q <= 1'b1;
            end else if (slot_close) begin
                inj_pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bchan_tap.sv
module bchan_tap
    import bchan_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DW        = 8,
    localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    input  logic          slot_tick,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] tx_pcm,
    output logic [DW-1:0] tx_line,
    output logic          tx_line_load,
    input  logic [DW-1:0] rx_line,
    output logic [DW-1:0] rx_path,
    output logic          rx_path_valid
);

    logic [SEL_W-1:0] sel_q;
    logic             slot_enter, slot_close;
    logic [DW-1:0]    tx_ins, rx_cap;
    logic             tx_pend, rx_new, rx_ovr, rx_inj_pend;
    logic [STAT_W-1:0] status;
    logic             wr_sel, wr_txins, wr_rxdata, rd_rxdata, rd_status;

    assign wr_sel    = reg_we && (reg_addr == RA_SEL);
    assign wr_txins  = reg_we && (reg_addr == RA_TXINS);
    assign wr_rxdata = reg_we && (reg_addr == RA_RXDATA);
    assign rd_rxdata = reg_re && (reg_addr == RA_RXDATA);
    assign rd_status = reg_re && (reg_addr == RA_STATUS);

    always_comb begin
        status           = '0;
        status[STAT_TXP] = tx_pend;
        status[STAT_RXI] = rx_inj_pend;
        status[STAT_NEW] = rx_new;
        status[STAT_OVR] = rx_ovr;
    end

    bchan_slot_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_tick(slot_tick),
        .sel(sel_q), .slot_enter(slot_enter), .slot_close(slot_close)
    );

    bchan_tx_lane #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .ins_wr(wr_txins), .wdata(reg_wdata),
        .slot_enter(slot_enter), .tx_pcm(tx_pcm), .ins_q(tx_ins), .pend_q(tx_pend),
        .tx_line(tx_line), .tx_line_load(tx_line_load)
    );

    bchan_rx_lane #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .inj_wr(wr_rxdata), .data_rd(rd_rxdata),
        .stat_rd(rd_status), .wdata(reg_wdata), .slot_close(slot_close),
        .rx_line(rx_line), .cap_q(rx_cap), .new_q(rx_new), .ovr_q(rx_ovr),
        .inj_pend_q(rx_inj_pend), .rx_path(rx_path), .rx_path_valid(rx_path_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            reg_rdata <= '0;
        end else begin
            if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
            if (reg_re) begin
                unique case (reg_addr)
                    RA_SEL:    reg_rdata <= {{(DW-SEL_W){1'b0}}, sel_q};
                    RA_TXINS:  reg_rdata <= tx_ins;
                    RA_RXDATA: reg_rdata <= rx_cap;
                    RA_STATUS: reg_rdata <= {{(DW-STAT_W){1'b0}}, status};
                    default:   reg_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/bchan_tap_chk.sv
module bchan_tap_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_line_load,
    input logic [DW-1:0] tx_line,
    input logic          rx_path_valid,
    input logic [DW-1:0] rx_path,
    input logic          tx_pend,
    input logic          rx_new,
    input logic          rx_ovr
);

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_line_load |=> !tx_line_load);                                  // R4
    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_line_load |-> $stable(tx_line));                              // R4
    AST_PEND_DROPS_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_pend) |-> tx_line_load);                                 // R5
    AST_CAPTURE_MARKS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_path_valid |-> rx_new);                                        // R6
    AST_OVR_NEEDS_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> ($past(rx_new) && rx_path_valid));              // R7
    AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_path_valid |=> !rx_path_valid);                                // R10
    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_path_valid |-> $stable(rx_path));                             // R10

endmodule

bind bchan_tap bchan_tap_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_line_load(tx_line_load), .tx_line(tx_line),
    .rx_path_valid(rx_path_valid), .rx_path(rx_path), .tx_pend(tx_pend),
    .rx_new(rx_new), .rx_ovr(rx_ovr)
);

// File: tb/test_bchan_tap.sv
module test_bchan_tap;

    localparam int NS = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_sync = 1'b0, slot_tick = 1'b0;
    logic          reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic [DW-1:0] tx_pcm = '0, tx_line, rx_line = '0, rx_path;
    logic          tx_line_load, rx_path_valid;

    int n_checks = 0, n_fail = 0;
    int tx_loads = 0, rx_loads = 0;
    logic [DW-1:0] last_tx = '0, last_rx = '0, rd;

    always #10 clk = ~clk;

    bchan_tap #(.NUM_SLOTS(NS), .DW(DW)) i_bchan_tap (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_tick(slot_tick),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_pcm(tx_pcm), .tx_line(tx_line),
        .tx_line_load(tx_line_load), .rx_line(rx_line), .rx_path(rx_path),
        .rx_path_valid(rx_path_valid)
    );

    always @(negedge clk) begin
        if (tx_line_load) begin last_tx = tx_line; tx_loads++; end
        if (rx_path_valid) begin last_rx = rx_path; rx_loads++; end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk); reg_re = 1'b1; reg_addr = a;
        @(negedge clk); reg_re = 1'b0;
        #1 d = reg_rdata;
    endtask

    function automatic logic [DW-1:0] rxv(input int f, input int s);
        return DW'((f << 4) | s);
    endfunction

    // one frame of NS four-cycle slots, then a closing frame tick
    task automatic run_frame(input int f, input logic [DW-1:0] pcm,
                             input int wslot, input logic [DW-1:0] wbyte);
        tx_loads = 0; rx_loads = 0;
        tx_pcm = pcm;
        for (int s = 0; s <= NS; s++) begin
            @(negedge clk); slot_tick = 1'b1; frame_sync = (s == 0) || (s == NS);
            @(negedge clk); slot_tick = 1'b0; frame_sync = 1'b0;
            rx_line = rxv(f, s);
            if (s == wslot) begin reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = wbyte; end
            @(negedge clk); reg_we = 1'b0;
            @(negedge clk);
        end
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        check(tx_line == 0 && !tx_line_load, "R1 tx outputs", tx_line, 0);
        check(rx_path == 0 && !rx_path_valid, "R1 rx outputs", rx_path, 0);
        reg_read(2'd3, rd); check(rd == 0, "R1 STATUS", rd, 0);
        reg_read(2'd0, rd); check(rd == 0, "R1 SEL", rd, 0);
        reg_read(2'd1, rd); check(rd == 0, "R1 TXINS", rd, 0);
    endtask

    task automatic t_normal();
        reg_write(2'd0, 8'd2);
        reg_read(2'd0, rd); check(rd == 2, "R2 SEL readback", rd, 2);
        run_frame(1, 8'h33, -1, 0);
        check(tx_loads == 1, "R2 one tx load", tx_loads, 1);
        check(last_tx == 8'h33, "R4 pcm passes", last_tx, 8'h33);
        check(rx_loads == 1, "R10 one rx pulse", rx_loads, 1);
        check(last_rx == rxv(1, 2), "R2 slot 2 captured", last_rx, rxv(1, 2));
    endtask

    task automatic t_insert();
        reg_write(2'd1, 8'hA5);
        reg_read(2'd3, rd); check(rd[0] == 1, "R5 pending set", rd, 1);
        run_frame(2, 8'h44, -1, 0);
        check(last_tx == 8'hA5, "R3 inserted byte sent", last_tx, 8'hA5);
        reg_read(2'd3, rd); check(rd[0] == 0, "R5 pending cleared", rd, 0);
        run_frame(3, 8'h45, -1, 0);
        check(last_tx == 8'h45, "R3 pcm resumes", last_tx, 8'h45);
    endtask

    task automatic t_capture();
        reg_read(2'd3, rd);
        check(rd[3] == 1, "R7 overrun after unread frames", rd, 8);
        reg_read(2'd2, rd); check(rd == rxv(3, 2), "R6 RXDATA latest", rd, rxv(3, 2));
        reg_read(2'd3, rd); check(rd[2] == 0 && rd[3] == 0, "R6 new cleared by read", rd, 0);
        run_frame(4, 8'h00, -1, 0);
        reg_read(2'd3, rd); check(rd[2] == 1 && rd[3] == 0, "R7 no overrun single", rd, 4);
        run_frame(5, 8'h00, -1, 0);
        reg_read(2'd3, rd); check(rd[3] == 1, "R7 overrun set", rd, 8);
        reg_read(2'd3, rd); check(rd[3] == 0, "R7 cleared by STATUS read", rd, 4);
        reg_read(2'd2, rd); check(rd == rxv(5, 2), "R6 RXDATA frame 5", rd, rxv(5, 2));
    endtask

    task automatic t_inject();
        reg_write(2'd2, 8'h77);
        reg_read(2'd3, rd); check(rd[1] == 1, "R8 inject pending", rd, 2);
        run_frame(6, 8'h00, -1, 0);
        check(last_rx == 8'h77, "R8 injected on rx path", last_rx, 8'h77);
        reg_read(2'd2, rd); check(rd == rxv(6, 2), "R8 RXDATA holds line byte", rd, rxv(6, 2));
        reg_read(2'd3, rd); check(rd[1] == 0, "R8 inject cleared", rd, 0);
        run_frame(7, 8'h00, -1, 0);
        check(last_rx == rxv(7, 2), "R10 line byte resumes", last_rx, rxv(7, 2));
    endtask

    task automatic t_mid_write();
        reg_write(2'd0, 8'd3);
        run_frame(8, 8'h11, 3, 8'hC3);
        check(last_tx == 8'h11, "R9 current slot untouched", last_tx, 8'h11);
        check(last_rx == rxv(8, 3), "R2 slot 3 captured", last_rx, rxv(8, 3));
        run_frame(9, 8'h12, -1, 0);
        check(last_tx == 8'hC3, "R9 applied next frame", last_tx, 8'hC3);
    endtask

    task automatic t_last_slot();
        reg_write(2'd0, NS - 1);
        run_frame(10, 8'h21, -1, 0);
        check(tx_loads == 1 && last_tx == 8'h21, "R2 last slot tx", last_tx, 8'h21);
        check(rx_loads == 1, "R2 last slot one capture", rx_loads, 1);
        check(last_rx == rxv(10, NS - 1), "R2 last slot byte", last_rx, rxv(10, NS - 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_normal();
        t_insert();
        t_capture();
        t_inject();
        t_mid_write();
        t_last_slot();
        summary();
    end

endmodule